// File: doc/BRIEF.md
# Lock-Bit Command Controller

This block is the command front end and operation sequencer for the protection bits of a flash-style array. It holds one lock bit per erase block and a single master lock bit. Software changes these bits with byte-wide bus writes. A setup byte comes first. The next write is a confirm byte that names the operation: lock one block, set the master lock, or unlock every block at once.

Before an operation starts, the controller checks the programming-supply flag and the master lock. An operation that passes both checks keeps the block busy for a fixed number of cycles, which stands in for the cell timing. The lock state changes on the cycle the operation completes. Each failure raises a fixed pair of sticky bits in an 8-bit status register. Once a command sequence begins, reads return that register until software selects array reads again.

The lock bits model non-volatile storage. They are initialised only by a separate power-up input. The ordinary controller reset does not change them. If an unlock-all is cut short by a supply drop or by the controller reset, the block raises an "undetermined" flag in place of corrupting the bits. A later successful unlock-all lowers that flag.

Top module: `lockbit_cmd_ctrl`

## Requirements
- R1: With both resets asserted and then released, `busy` is 0, `lock_vec` and `master_lock` are 0, `lock_unknown` is 0, and reads return array data (`rd_data` = {7'b0, `lock_vec[rd_addr]`}).
- R2: Writing 60h and then 01h to address A, with `vpp_ok` high and the master lock clear, raises `busy` on the cycle after the confirm write. `busy` stays high for exactly OP_CYCLES cycles. `lock_vec[A]` is 1 from the cycle `busy` falls, and no other bit changes.
- R3: Status bit 7 reads 0 while `busy` is high and 1 otherwise. After a 60h write, reads return the status register until an FFh write.
- R4: Writing 60h and then D0h with `vpp_ok` high and the master lock clear sets all bits of `lock_vec` to 0 at the same completion edge. It also sets `lock_unknown` to 0.
- R5: A confirm byte that is not 01h, F1h or D0h starts no operation, leaves the lock state unchanged, and sets status bits 4 and 5.
- R6: A block-lock sequence while the master lock is set starts no operation, changes no lock bit, and sets status bits 1 and 4.
- R7: An unlock-all sequence while the master lock is set starts no operation, changes no lock bit, and sets status bits 1 and 5.
- R8: When `vpp_ok` is low at the confirm write, no operation starts and no lock bit changes. The block sets status bits 3 and 5 for an unlock-all, or bits 3 and 4 for a lock. The supply check takes priority over the master-lock check.
- R9: Writing 60h and then F1h sets `master_lock` after the busy period. After that, only the power-up input clears it.
- R10: Error bits (1, 3, 4, 5) stay set until a 50h write, which clears them. Writes made while `busy` is high have no effect.
- R11: If `vpp_ok` falls, or `rst_n` is asserted, while an unlock-all is busy, the operation stops and `lock_vec` is left unchanged. `lock_unknown` becomes 1. A supply abort also sets status bits 3 and 5.
- R12: In array-read mode, `rd_data` is {7'b0, `lock_vec[rd_addr]`}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low controller reset; lock storage keeps its contents |
| pwr_on_n | input | 1 | Synchronous active-low power-up initialisation of the lock storage |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | BLK_W | Block index carried by the confirm write |
| wr_data | input | 8 | Command byte |
| rd_addr | input | BLK_W | Block index for array reads |
| rd_data | output | 8 | Status register or addressed lock bit, depending on read mode |
| vpp_ok | input | 1 | Programming supply is above the lockout level |
| busy | output | 1 | An operation is in progress |
| lock_vec | output | NBLK | Per-block lock bits |
| master_lock | output | 1 | Master lock bit |
| lock_unknown | output | 1 | An unlock-all was aborted, so the lock bits are undetermined |

## Verification
The bench targets the ordering of the pre-start checks. With both the supply low and the master lock set, the result must show the supply bits. A design that checks the master lock first would report bit 1 instead of bit 3. It also aborts an unlock-all mid-operation, once by dropping the supply and once by a controller reset. A design that committed the clear, or skipped the undetermined flag, would show an empty lock vector or a low flag. Writes made during the busy window and a malformed confirm byte are also tried. A design that accepted either would change the read mode or start an operation, which would show up as a wrong status value or changed lock bits.

// File: rtl/lockcmd_pkg.sv
// Shared command codes, read modes, operation kinds and status masks for
// the lock-bit command controller. Assumes an 8-bit command bus.
package lockcmd_pkg;

    localparam logic [7:0] CMD_SETUP      = 8'h60;
    localparam logic [7:0] CMD_CONF_BLK   = 8'h01;
    localparam logic [7:0] CMD_CONF_MSTR  = 8'hF1;
    localparam logic [7:0] CMD_CONF_CLR   = 8'hD0;
    localparam logic [7:0] CMD_CLR_STAT   = 8'h50;
    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;

    // Status register bit positions (visible to software)
    localparam int SR_READY    = 7;
    localparam int SR_CLR_FAIL = 5;
    localparam int SR_SET_FAIL = 4;
    localparam int SR_SUPPLY   = 3;
    localparam int SR_MASTER   = 1;

    localparam logic [7:0] MSK_CLR_FAIL = 8'(1) << SR_CLR_FAIL;
    localparam logic [7:0] MSK_SET_FAIL = 8'(1) << SR_SET_FAIL;
    localparam logic [7:0] MSK_SUPPLY   = 8'(1) << SR_SUPPLY;
    localparam logic [7:0] MSK_MASTER   = 8'(1) << SR_MASTER;
    localparam logic [7:0] MSK_BAD_SEQ  = MSK_CLR_FAIL | MSK_SET_FAIL;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_STATUS = 2'd1,
        MODE_SETUP  = 2'd2
    } rd_mode_t;

    typedef enum logic [1:0] {
        OP_NONE     = 2'd0,
        OP_LOCK_BLK = 2'd1,
        OP_LOCK_MST = 2'd2,
        OP_CLR_ALL  = 2'd3
    } op_kind_t;

    // Failure bit that accompanies a cause bit for a given operation kind
    function automatic logic [7:0] fail_bit(op_kind_t k);
        return (k == OP_CLR_ALL) ? MSK_CLR_FAIL : MSK_SET_FAIL;
    endfunction

endpackage

// File: rtl/lockcmd_decoder.sv
// Command decoder: interprets bus writes, tracks the read mode and the
// pending setup, runs the supply and master-lock checks at confirm time,
// and either launches an operation or reports the failure mask.
// Assumes writes are ignored while an operation is busy.
module lockcmd_decoder
    import lockcmd_pkg::*;
#(
    parameter int BLK_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BLK_W-1:0] wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             busy,
    input  logic             vpp_ok,
    input  logic             master_lock,
    output rd_mode_t         mode,
    output logic             launch,
    output op_kind_t         kind,
    output logic [BLK_W-1:0] blk,
    output logic [7:0]       err_mask,
    output logic             clr_stat
);

    rd_mode_t         mode_q, mode_d;
    op_kind_t         kind_q, kind_d;
    logic [BLK_W-1:0] blk_q;

    // Decode the current write against the read mode and the pre-start checks
    always_comb begin
        mode_d   = mode_q;
        kind_d   = OP_NONE;
        launch   = 1'b0;
        err_mask = 8'h00;
        clr_stat = 1'b0;
        if (wr_en && !busy) begin
            if (mode_q == MODE_SETUP) begin
                mode_d = MODE_STATUS;
                case (wr_data)
                    CMD_CONF_BLK:  kind_d = OP_LOCK_BLK;
                    CMD_CONF_MSTR: kind_d = OP_LOCK_MST;
                    CMD_CONF_CLR:  kind_d = OP_CLR_ALL;
                    default:       kind_d = OP_NONE;
                endcase
                if (kind_d == OP_NONE) begin
                    err_mask = MSK_BAD_SEQ;
                end else if (!vpp_ok) begin
                    err_mask = MSK_SUPPLY | fail_bit(kind_d);
                end else if (master_lock && kind_d != OP_LOCK_MST) begin
                    err_mask = MSK_MASTER | fail_bit(kind_d);
                end else begin
                    launch = 1'b1;
                end
            end else begin
                case (wr_data)
                    CMD_SETUP:      mode_d   = MODE_SETUP;
                    CMD_CLR_STAT:   clr_stat = 1'b1;
                    CMD_READ_ARRAY: mode_d   = MODE_ARRAY;
                    default:        mode_d   = mode_q;
                endcase
            end
        end
    end

    // Hold the read mode and the parameters of the running operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_ARRAY;
            kind_q <= OP_NONE;
            blk_q  <= '0;
        end else begin
            mode_q <= mode_d;
            if (launch) begin
                kind_q <= kind_d;
                blk_q  <= wr_addr;
            end
        end
    end

    assign mode = mode_q;
    assign kind = kind_q;
    assign blk  = blk_q;

endmodule

// File: rtl/lockcmd_timer.sv
// Operation timer: stands in for cell timing with a down-counter. Busy
// lasts OP_CYCLES cycles. Completion fires on the last one if the supply
// is still valid. A supply drop while busy ends the operation as an abort.
module lockcmd_timer #(
    parameter int OP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic vpp_ok,
    output logic busy,
    output logic done,
    output logic abort
);

    localparam int CNT_W = $clog2(OP_CYCLES + 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    // Count down the busy window and stop on completion or supply loss
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (launch) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(OP_CYCLES - 1);
        end else if (busy_q && (!vpp_ok || cnt_q == '0)) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy  = busy_q;
    assign done  = busy_q && vpp_ok && (cnt_q == '0);
    assign abort = busy_q && !vpp_ok;

endmodule

// File: rtl/lockcmd_store.sv
// Lock storage: models the non-volatile per-block lock bits, the master
// lock and the undetermined flag. Only pwr_on_n initialises it. The
// controller reset only marks an unlock-all that it interrupts.
module lockcmd_store
    import lockcmd_pkg::*;
#(
    parameter int NBLK  = 8,
    parameter int BLK_W = 3
) (
    input  logic             clk,
    input  logic             pwr_on_n,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             done,
    input  logic             abort,
    input  op_kind_t         kind,
    input  logic [BLK_W-1:0] blk,
    output logic [NBLK-1:0]  lock_vec,
    output logic             master_lock,
    output logic             lock_unknown
);

    logic [NBLK-1:0] lock_q;
    logic            mstr_q;
    logic            unk_q;
    logic            clr_cut;

    // An unlock-all stopped by reset or by supply loss
    assign clr_cut = (kind == OP_CLR_ALL) && ((!rst_n && busy) || (rst_n && abort));

    // Apply completed operations and record interrupted unlock-alls
    always_ff @(posedge clk) begin
        if (!pwr_on_n) begin
            lock_q <= '0;
            mstr_q <= 1'b0;
            unk_q  <= 1'b0;
        end else if (clr_cut) begin
            unk_q <= 1'b1;
        end else if (rst_n && done) begin
            case (kind)
                OP_LOCK_BLK: lock_q[blk] <= 1'b1;
                OP_LOCK_MST: mstr_q      <= 1'b1;
                OP_CLR_ALL: begin
                    lock_q <= '0;
                    unk_q  <= 1'b0;
                end
                default: lock_q <= lock_q;
            endcase
        end
    end

    assign lock_vec     = lock_q;
    assign master_lock  = mstr_q;
    assign lock_unknown = unk_q;

endmodule

// File: rtl/lockcmd_status.sv
// Status register: sticky error bits set from the decoder and timer masks,
// cleared by the clear-status command or the controller reset. Bit 7 is
// the inverted busy flag.
module lockcmd_status
    import lockcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy,
    input  logic       clr_stat,
    input  logic [7:0] set_mask,
    input  logic [7:0] abort_mask,
    output logic [7:0] status
);

    logic [5:0] err_q;

    // Accumulate error bits until software clears them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else if (clr_stat) begin
            err_q <= '0;
        end else begin
            err_q <= err_q | set_mask[5:0] | abort_mask[5:0];
        end
    end

    assign status = {~busy, 1'b0, err_q};

endmodule

// File: rtl/lockbit_cmd_ctrl.sv
// Lock-bit command controller top: wires the decoder, the timer, the lock
// storage and the status register, and selects the read data by mode.
// Assumes NBLK is a power of two and OP_CYCLES >= 1.
module lockbit_cmd_ctrl
    import lockcmd_pkg::*;
#(
    parameter int NBLK      = 8,
    parameter int OP_CYCLES = 4,
    localparam int BLK_W    = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_on_n,
    input  logic             wr_en,
    input  logic [BLK_W-1:0] wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [BLK_W-1:0] rd_addr,
    output logic [7:0]       rd_data,
    input  logic             vpp_ok,
    output logic             busy,
    output logic [NBLK-1:0]  lock_vec,
    output logic             master_lock,
    output logic             lock_unknown
);

    rd_mode_t         mode;
    op_kind_t         kind;
    logic [BLK_W-1:0] blk;
    logic             launch;
    logic             done;
    logic             abort;
    logic             clr_stat;
    logic [7:0]       err_mask;
    logic [7:0]       abort_mask;
    logic [7:0]       status_q;

    lockcmd_decoder #(.BLK_W(BLK_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .vpp_ok(vpp_ok),
        .master_lock(master_lock), .mode(mode), .launch(launch),
        .kind(kind), .blk(blk), .err_mask(err_mask), .clr_stat(clr_stat)
    );

    lockcmd_timer #(.OP_CYCLES(OP_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .launch(launch), .vpp_ok(vpp_ok),
        .busy(busy), .done(done), .abort(abort)
    );

    lockcmd_store #(.NBLK(NBLK), .BLK_W(BLK_W)) u_store (
        .clk(clk), .pwr_on_n(pwr_on_n), .rst_n(rst_n), .busy(busy),
        .done(done), .abort(abort), .kind(kind), .blk(blk),
        .lock_vec(lock_vec), .master_lock(master_lock),
        .lock_unknown(lock_unknown)
    );

    // Status bits raised by a supply abort, by operation kind
    assign abort_mask = abort ? (MSK_SUPPLY | fail_bit(kind)) : 8'h00;

    lockcmd_status u_stat (
        .clk(clk), .rst_n(rst_n), .busy(busy), .clr_stat(clr_stat),
        .set_mask(err_mask), .abort_mask(abort_mask), .status(status_q)
    );

    // Read data: addressed lock bit in array mode, status otherwise
    always_comb begin
        if (mode == MODE_ARRAY) rd_data = {7'b0, lock_vec[rd_addr]};
        else                    rd_data = status_q;
    end

endmodule

// File: rtl/lockbit_cmd_ctrl_chk.sv
// Checker for the lock-bit command controller: temporal properties over
// the top-level ports and the read mode, attached with bind.
module lockbit_cmd_ctrl_chk
    import lockcmd_pkg::*;
#(
    parameter int NBLK      = 8,
    parameter int OP_CYCLES = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pwr_on_n,
    input logic            wr_en,
    input logic            vpp_ok,
    input logic            busy,
    input logic [NBLK-1:0] lock_vec,
    input logic            master_lock,
    input rd_mode_t        mode
);

    localparam int RUN_W = $clog2(OP_CYCLES + 2);
    logic [RUN_W-1:0] run_len;

    // Length of the current busy run
    always_ff @(posedge clk) begin
        if (!rst_n) run_len <= '0;
        else if (busy) run_len <= (run_len == RUN_W'(OP_CYCLES + 1)) ? run_len : run_len + 1'b1;
        else run_len <= '0;
    end

    // R2: a busy window never outlasts OP_CYCLES
    always_ff @(posedge clk) begin
        if (rst_n) a_r2_busy_window: assert (run_len <= RUN_W'(OP_CYCLES))
            else $error("busy longer than OP_CYCLES");
    end

    // R9: the master lock never falls without power-up
    a_r9_master_sticky: assert property (@(posedge clk) disable iff (!pwr_on_n)
        master_lock |=> master_lock);

    // R7: with the master lock set no lock bit is cleared
    a_r7_master_holds_locks: assert property (@(posedge clk) disable iff (!pwr_on_n)
        master_lock |=> ((lock_vec & $past(lock_vec)) == $past(lock_vec)));

    // R8: lock bits cannot change while the supply is low
    a_r8_supply_freezes: assert property (@(posedge clk) disable iff (!pwr_on_n)
        !vpp_ok |=> (lock_vec == $past(lock_vec)));

    // R4: any bit that clears does so together with all others
    a_r4_clear_all_together: assert property (@(posedge clk) disable iff (!pwr_on_n)
        (($past(lock_vec) & ~lock_vec) != '0) |-> (lock_vec == '0));

    // R10: a write during busy leaves the read mode alone
    a_r10_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> (mode == $past(mode)));

endmodule

bind lockbit_cmd_ctrl lockbit_cmd_ctrl_chk #(.NBLK(NBLK), .OP_CYCLES(OP_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_on_n(pwr_on_n), .wr_en(wr_en),
    .vpp_ok(vpp_ok), .busy(busy), .lock_vec(lock_vec),
    .master_lock(master_lock), .mode(mode)
);

// File: tb/test_lockbit_cmd_ctrl.sv
// Bench: directed corner cases plus seeded random operation mix, checked
// against a reference model held in bench variables.
module test_lockbit_cmd_ctrl;

    localparam int NBLK      = 8;
    localparam int OP_CYCLES = 4;
    localparam int BLK_W     = $clog2(NBLK);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pwr_on_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [BLK_W-1:0] wr_addr = '0;
    logic [7:0]       wr_data = 8'h00;
    logic [BLK_W-1:0] rd_addr = '0;
    logic [7:0]       rd_data;
    logic             vpp_ok = 1'b1;
    logic             busy;
    logic [NBLK-1:0]  lock_vec;
    logic             master_lock;
    logic             lock_unknown;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // Reference model
    logic [NBLK-1:0] m_lock = '0;
    logic            m_mstr = 1'b0;
    logic            m_unk  = 1'b0;
    logic [7:0]      m_err  = 8'h00;

    always #4 clk = ~clk;

    lockbit_cmd_ctrl #(.NBLK(NBLK), .OP_CYCLES(OP_CYCLES)) i_lockbit_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_on_n(pwr_on_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .vpp_ok(vpp_ok), .busy(busy),
        .lock_vec(lock_vec), .master_lock(master_lock),
        .lock_unknown(lock_unknown)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [BLK_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Expected failure mask for an operation kind (0 lock, 1 master, 2 clear, 3 bad)
    function automatic logic [7:0] exp_err(int kind, bit vpp, bit mstr);
        logic [7:0] f;
        f = (kind == 2) ? 8'h20 : 8'h10;
        if (kind == 3) return 8'h30;
        if (!vpp) return 8'h08 | f;
        if (mstr && kind != 1) return 8'h02 | f;
        return 8'h00;
    endfunction

    function automatic logic [7:0] code_of(int kind);
        case (kind)
            0: return 8'h01;
            1: return 8'hF1;
            2: return 8'hD0;
            default: return 8'h22;
        endcase
    endfunction

    task automatic check_state(input string tag);
        chk({tag, " locks"}, 32'(lock_vec), 32'(m_lock));
        chk({tag, " master"}, 32'(master_lock), 32'(m_mstr));
        chk({tag, " unknown"}, 32'(lock_unknown), 32'(m_unk));
        chk({tag, " status"}, 32'(rd_data), 32'(8'h80 | m_err));
    endtask

    // Issue one two-write sequence and check timing and outcome
    task automatic run_op(input int kind, input int blk, input bit vpp, input string tag);
        logic [7:0] e;
        int n;
        vpp_ok = vpp;
        wr(BLK_W'(blk), 8'h60);
        wr(BLK_W'(blk), code_of(kind));
        e = exp_err(kind, vpp, m_mstr);
        if (e != 8'h00) begin
            chk({tag, " no launch"}, 32'(busy), 32'd0);
            m_err |= e;
        end else begin
            chk("R3 ready low while busy", 32'(rd_data[7]), 32'd0);
            n = 0;
            while (busy && n < 100) begin
                n++;
                @(negedge clk);
            end
            chk("R2 busy length", 32'(n), 32'(OP_CYCLES));
            case (kind)
                0: m_lock[blk] = 1'b1;
                1: m_mstr = 1'b1;
                default: begin m_lock = '0; m_unk = 1'b0; end
            endcase
        end
        vpp_ok = 1'b1;
        check_state(tag);
    endtask

    task automatic clear_status();
        wr('0, 8'h50);
        m_err = 8'h00;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; pwr_on_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 locks", 32'(lock_vec), 32'd0);
        chk("R1 master", 32'(master_lock), 32'd0);
        chk("R1 unknown", 32'(lock_unknown), 32'd0);
        chk("R1 array read", 32'(rd_data), 32'd0);

        run_op(0, 3, 1'b1, "R2 lock block 3");
        // R12 array reads
        wr('0, 8'hFF);
        rd_addr = 3; #1;
        chk("R12 locked block reads 1", 32'(rd_data), 32'd1);
        rd_addr = 2; #1;
        chk("R12 free block reads 0", 32'(rd_data), 32'd0);
        wr('0, 8'h50);
        chk("R12 stays array after clear-status", 32'(rd_data), 32'd0);

        run_op(3, 5, 1'b1, "R5 malformed confirm");
        run_op(0, 6, 1'b1, "R10 sticky across success");
        // R10 write during busy ignored
        wr(1, 8'h60); wr(1, 8'h01);
        wr('0, 8'hFF);
        while (busy) @(negedge clk);
        m_lock[1] = 1'b1;
        chk("R10 busy write ignored, still status", 32'(rd_data), 32'(8'h80 | m_err));
        clear_status();
        check_state("R10 clear status");

        run_op(2, 0, 1'b0, "R8 clear with supply low");
        run_op(0, 4, 1'b0, "R8 lock with supply low");
        clear_status();

        // R11 supply abort during clear
        wr('0, 8'h60); wr('0, 8'hD0);
        vpp_ok = 1'b0;
        @(negedge clk);
        chk("R11 abort ends busy", 32'(busy), 32'd0);
        vpp_ok = 1'b1;
        m_unk = 1'b1; m_err |= 8'h28;
        check_state("R11 supply abort");
        clear_status();
        run_op(2, 0, 1'b1, "R4 clear resets all and unknown");

        // R11 reset abort during clear
        run_op(0, 2, 1'b1, "R11 prep lock 2");
        wr('0, 8'h60); wr('0, 8'hD0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_unk = 1'b1; m_err = 8'h00;
        chk("R11 reset abort busy", 32'(busy), 32'd0);
        chk("R11 reset abort locks kept", 32'(lock_vec), 32'(m_lock));
        chk("R11 reset abort unknown", 32'(lock_unknown), 32'd1);
        rd_addr = 2; #1;
        chk("R1 array mode after reset", 32'(rd_data), 32'd1);

        // Random mix
        for (int i = 0; i < 200; i++) begin
            int r, kind, blk;
            bit vpp;
            r    = $urandom(1000 + i);
            kind = (r % 16 == 0) ? 1 : (r % 16 < 7) ? 0 : (r % 16 < 11) ? 2 : 3;
            blk  = (r >> 8) % NBLK;
            vpp  = ((r >> 16) % 5) != 0;
            run_op(kind, blk, vpp, (kind == 2) ? "R4 random clear" :
                                   (kind == 3) ? "R5 random bad" : "R2 random lock");
            if (((r >> 20) % 3) == 0) clear_status();
        end

        // Master lock cases
        clear_status();
        run_op(1, 0, 1'b1, "R9 set master");
        run_op(0, 7, 1'b1, "R6 lock under master");
        run_op(2, 0, 1'b1, "R7 clear under master");
        run_op(2, 0, 1'b0, "R8 supply checked before master");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 master survives reset", 32'(master_lock), 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule